// File: doc/BRIEF.md
# Masked Condition-Field Lookup-Table Logic Unit

This unit evaluates one of two bitwise lookup operations on a single 4-bit field of a 32-bit condition register. The register holds eight fields. A field index names a destination and up to two sources. In the ternary operation, each destination bit, together with the matching bits of two source fields, selects one entry of an 8-entry truth table carried in the instruction. In the binary operation, the destination bit and one source bit select an entry of a 4-entry table taken from a third field of the register.

A 4-bit write mask picks which destination bits take the new value. The other destination bits keep their old value, so each operation is a conditional read-modify-write of one field. Both the mask and the ternary table are split across non-contiguous instruction bits. An all-zero mask, or an instruction this unit does not recognise, raises an illegal-instruction flag and leaves the register untouched.

The caller presents an instruction word and the current register value every clock. One cycle later the unit returns the next register value and the flag.

Top module: `cr_lut_unit`

## Requirements
- R1: Field F (0..7) occupies `crIn[31-4F -: 4]`. Bit 0 of a field is the most significant bit of that nibble and bit 3 is its least significant bit.
- R2: Ternary operation: for each field bit i, the index j = {dst bit i, srcA bit i, srcB bit i}, with the destination as MSB, selects table bit j. Table bits 0..6 are instruction bits 19..25 and table bit 7 is instruction bit 31. Instruction bits are numbered MSB-first, so instruction bit k is `instrIn[31-k]`.
- R3: Binary operation: for each field bit i, j = {dst bit i, srcA bit i}, with the destination as MSB, selects bit j of field srcB (field bit numbering as in R1).
- R4: Mask bit 0 is instruction bit 9, bit 1 is bit 10, bit 2 is bit 14 and bit 3 is bit 15. Mask bit i controls field bit i. A destination bit whose mask bit is 0 keeps its old value.
- R5: An all-zero mask sets `illegalOut` to 1 and makes `crOut` equal to the sampled `crIn`.
- R6: Every field other than the destination leaves the unit unchanged.
- R7: When the destination index equals a source index, every read uses the field's value before the write.
- R8: In the binary operation, instruction bits 19..25 and bit 31 have no effect on the result.
- R9: Instruction bits 0..5 must equal `MAJOR_OP`, and bits 26..30 must equal `TERN_XO` (ternary) or `BIN_XO` (binary). Otherwise the instruction is illegal, as in R5. Destination, srcA and srcB are instruction bits 6..8, 11..13 and 16..18.
- R10: Outputs are registered with a latency of one clock. While `rstN` is low, `crOut` is 0 and `illegalOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrIn | input | 32 | Instruction word |
| crIn | input | 32 | Current condition register |
| crOut | output | 32 | Next condition register, one cycle after sampling |
| illegalOut | output | 1 | Illegal-instruction flag, aligned with `crOut` |

## Verification
A wrong field-index decode shows one cycle later as a change in a field that should have kept its value. A corrupted mask decode shows in the same cycle as a bit that was preserved when it should have been written, or written when it should have been preserved. A table or lane-order error flips single bits of the destination nibble. The vectors are chosen so that each of these lands on a different bit pattern. A trap path that leaks a write appears as `crOut` differing from the previous `crIn` while the flag is high. Reads taken after the write appear only in the aliasing cases.

// File: rtl/cr_lut_pkg.sv
package cr_lut_pkg;
  localparam int INSTR_W    = 32;
  localparam int IDX_W      = 3;
  localparam int NUM_FIELDS = 1 << IDX_W;
  localparam int FIELD_W    = 4;
  localparam int CR_W       = FIELD_W * NUM_FIELDS;
  localparam int TBL_W      = 1 << 3;
  localparam int PO_W       = 6;
  localparam int XO_W       = 5;

  // MSB-first instruction bit positions
  localparam int POS_DST  = 6;
  localparam int POS_SRCA = 11;
  localparam int POS_SRCB = 16;
  localparam int POS_TBL  = 19;
  localparam int POS_XO   = 26;
  localparam int POS_LAST = 31;

  typedef struct packed {
    logic writeEn;
    logic binaryMode;
    logic trap;
  } strobes_t;
endpackage

// File: rtl/cr_lut_ctrl.sv
module cr_lut_ctrl
  import cr_lut_pkg::*;
#(
  parameter logic [PO_W-1:0] MAJOR_OP = 6'd22,
  parameter logic [XO_W-1:0] TERN_XO  = 5'd10,
  parameter logic [XO_W-1:0] BIN_XO   = 5'd11
) (
  input  logic [INSTR_W-1:0] instr,
  output strobes_t           stb,
  output logic [IDX_W-1:0]   dstIdx,
  output logic [IDX_W-1:0]   srcAIdx,
  output logic [IDX_W-1:0]   srcBIdx,
  output logic [FIELD_W-1:0] mask,
  output logic [TBL_W-1:0]   truthTbl
);
  localparam int MSB = INSTR_W - 1;

  logic [PO_W-1:0] majorOp;
  logic [XO_W-1:0] extOp;
  logic isTern, isBin, legalOp, maskZero;

  assign majorOp = instr[MSB -: PO_W];
  assign extOp   = instr[MSB-POS_XO -: XO_W];
  assign dstIdx  = instr[MSB-POS_DST -: IDX_W];
  assign srcAIdx = instr[MSB-POS_SRCA -: IDX_W];
  assign srcBIdx = instr[MSB-POS_SRCB -: IDX_W];

  // mask pieces: two bits after the destination, two after source A
  assign mask[0] = instr[MSB-(POS_DST+IDX_W)];
  assign mask[1] = instr[MSB-(POS_DST+IDX_W+1)];
  assign mask[2] = instr[MSB-(POS_SRCA+IDX_W)];
  assign mask[3] = instr[MSB-(POS_SRCA+IDX_W+1)];

  for (genvar t = 0; t < TBL_W - 1; t++) begin : g_tbl
    assign truthTbl[t] = instr[MSB-(POS_TBL+t)];
  end
  assign truthTbl[TBL_W-1] = instr[MSB-POS_LAST];

  always_comb begin
    isTern   = (majorOp == MAJOR_OP) && (extOp == TERN_XO);
    isBin    = (majorOp == MAJOR_OP) && (extOp == BIN_XO);
    legalOp  = isTern || isBin;
    maskZero = (mask == '0);
    stb.trap       = !legalOp || maskZero;
    stb.writeEn    = !stb.trap;
    stb.binaryMode = isBin;
  end
endmodule

// File: rtl/cr_lut_datapath.sv
module cr_lut_datapath
  import cr_lut_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [IDX_W-1:0]   dstIdx,
  input  logic [IDX_W-1:0]   srcAIdx,
  input  logic [IDX_W-1:0]   srcBIdx,
  input  logic [FIELD_W-1:0] mask,
  input  logic [TBL_W-1:0]   truthTbl,
  input  logic [CR_W-1:0]    crIn,
  output logic [CR_W-1:0]    crOut,
  output logic               illegalOut
);
  logic [FIELD_W-1:0] fieldArr [NUM_FIELDS];
  logic [FIELD_W-1:0] dstOld, srcA, srcB, lutRev, merged;
  logic [CR_W-1:0]    crNext;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_split
    assign fieldArr[f] = crIn[CR_W-1-FIELD_W*f -: FIELD_W];
  end

  // all reads come from crIn, before any write
  assign dstOld = fieldArr[dstIdx];
  assign srcA   = fieldArr[srcAIdx];
  assign srcB   = fieldArr[srcBIdx];

  // lutRev[k] is field bit k of srcB
  for (genvar k = 0; k < FIELD_W; k++) begin : g_rev
    assign lutRev[k] = srcB[FIELD_W-1-k];
  end

  for (genvar i = 0; i < FIELD_W; i++) begin : g_lane
    localparam int P = FIELD_W - 1 - i;
    logic [2:0] ternSel;
    logic [1:0] binSel;
    logic       newBit;
    assign ternSel   = {dstOld[P], srcA[P], srcB[P]};
    assign binSel    = {dstOld[P], srcA[P]};
    assign newBit    = stb.binaryMode ? lutRev[binSel] : truthTbl[ternSel];
    assign merged[P] = mask[i] ? newBit : dstOld[P];
  end

  always_comb begin
    crNext = crIn;
    if (stb.writeEn) begin
      for (int f = 0; f < NUM_FIELDS; f++) begin
        if (dstIdx == IDX_W'(f)) crNext[CR_W-1-FIELD_W*f -: FIELD_W] = merged;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crOut      <= '0;
      illegalOut <= 1'b0;
    end else begin
      crOut      <= crNext;
      illegalOut <= stb.trap;
    end
  end
endmodule

// File: rtl/cr_lut_unit.sv
module cr_lut_unit
  import cr_lut_pkg::*;
#(
  parameter logic [5:0] MAJOR_OP = 6'd22,
  parameter logic [4:0] TERN_XO  = 5'd10,
  parameter logic [4:0] BIN_XO   = 5'd11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] instrIn,
  input  logic [31:0] crIn,
  output logic [31:0] crOut,
  output logic        illegalOut
);
  strobes_t           stb;
  logic [IDX_W-1:0]   dstIdx, srcAIdx, srcBIdx;
  logic [FIELD_W-1:0] mask;
  logic [TBL_W-1:0]   truthTbl;

  cr_lut_ctrl #(
    .MAJOR_OP(MAJOR_OP), .TERN_XO(TERN_XO), .BIN_XO(BIN_XO)
  ) u_ctrl (
    .instr(instrIn), .stb(stb), .dstIdx(dstIdx), .srcAIdx(srcAIdx),
    .srcBIdx(srcBIdx), .mask(mask), .truthTbl(truthTbl)
  );

  cr_lut_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dstIdx(dstIdx), .srcAIdx(srcAIdx),
    .srcBIdx(srcBIdx), .mask(mask), .truthTbl(truthTbl), .crIn(crIn),
    .crOut(crOut), .illegalOut(illegalOut)
  );
endmodule

// File: rtl/cr_lut_checker.sv
module cr_lut_checker #(
  parameter logic [5:0] MAJOR_OP = 6'd22
) (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  dstIn,
  input logic [3:0]  maskIn,
  input logic [5:0]  poIn,
  input logic [31:0] crIn,
  input logic [31:0] crOut,
  input logic        illegalOut
);
  logic        primed;
  logic [2:0]  prevDst;
  logic [3:0]  prevMask;
  logic [5:0]  prevPo;
  logic [31:0] prevCr;
  int          lanePos [4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed <= 1'b0; prevDst <= '0; prevMask <= '0; prevPo <= '0; prevCr <= '0;
    end else begin
      primed <= 1'b1; prevDst <= dstIn; prevMask <= maskIn; prevPo <= poIn; prevCr <= crIn;
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) lanePos[i] = 31 - 4 * int'(prevDst) - i;
  end

  assert_trap_keeps_cr_R5: assert property (@(posedge clk) disable iff (!rstN || !primed)
    illegalOut |-> crOut == prevCr);

  assert_zero_mask_traps_R5: assert property (@(posedge clk) disable iff (!rstN || !primed)
    (prevMask == 4'd0) |-> illegalOut);

  assert_bad_major_traps_R9: assert property (@(posedge clk) disable iff (!rstN || !primed)
    (prevPo != MAJOR_OP) |-> illegalOut);

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assert_masked_bit_kept_R4: assert property (@(posedge clk) disable iff (!rstN || !primed)
      (!illegalOut && !prevMask[i]) |-> crOut[lanePos[i]] == prevCr[lanePos[i]]);
  end

  for (genvar f = 0; f < 8; f++) begin : g_field
    assert_other_field_kept_R6: assert property (@(posedge clk) disable iff (!rstN || !primed)
      (prevDst != 3'(f)) |-> crOut[31-4*f -: 4] == prevCr[31-4*f -: 4]);
  end
endmodule

bind cr_lut_unit cr_lut_checker #(.MAJOR_OP(MAJOR_OP)) u_chk (
  .clk(clk), .rstN(rstN), .dstIn(instrIn[25:23]),
  .maskIn({instrIn[16], instrIn[17], instrIn[21], instrIn[22]}),
  .poIn(instrIn[31:26]), .crIn(crIn), .crOut(crOut), .illegalOut(illegalOut)
);

// File: tb/sim_cr_lut_unit.sv
module sim_cr_lut_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] MAJ  = 6'd22;
  localparam logic [4:0] XO_T = 5'd10;
  localparam logic [4:0] XO_B = 5'd11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] instrIn = '0;
  logic [31:0] crIn = '0;
  logic [31:0] crOut;
  logic illegalOut;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cr_lut_unit u0 (.clk(clk), .rstN(rstN), .instrIn(instrIn), .crIn(crIn),
                  .crOut(crOut), .illegalOut(illegalOut));

  typedef struct packed {
    logic        isBin;
    logic [2:0]  dst, srcA, srcB;
    logic [3:0]  mask;
    logic [7:0]  tbl;
    logic [31:0] cr;
    logic [31:0] exp;
    logic        ill;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 3'd1, 3'd2, 4'hF, 8'hAA, 32'h35C00000, 32'hC5C00000, 1'b0, 8'd2},  // R2 copy srcB, R1
    '{1'b0, 3'd0, 3'd1, 3'd2, 4'hF, 8'hCC, 32'h35C00000, 32'h55C00000, 1'b0, 8'd2},  // R2 copy srcA
    '{1'b0, 3'd0, 3'd1, 3'd2, 4'hF, 8'h80, 32'hEB700000, 32'h2B700000, 1'b0, 8'd2},  // R2 and3
    '{1'b0, 3'd0, 3'd1, 3'd2, 4'hF, 8'hFE, 32'hEB700000, 32'hFB700000, 1'b0, 8'd2},  // R2 or3
    '{1'b0, 3'd0, 3'd1, 3'd2, 4'h9, 8'h00, 32'hEB700000, 32'h6B700000, 1'b0, 8'd4},  // R4 lanes 0,3
    '{1'b1, 3'd3, 3'd4, 3'd5, 4'hF, 8'h00, 32'h000CA600, 32'h0006A600, 1'b0, 8'd3},  // R3 xor lut
    '{1'b1, 3'd3, 3'd4, 3'd5, 4'hF, 8'h00, 32'h000CA800, 32'h0001A800, 1'b0, 8'd3},  // R3 nor lut
    '{1'b1, 3'd2, 3'd2, 3'd2, 4'hF, 8'h00, 32'h00900000, 32'h00F00000, 1'b0, 8'd7},  // R7 binary alias
    '{1'b0, 3'd7, 3'd7, 3'd7, 4'hF, 8'h01, 32'h00000003, 32'h0000000C, 1'b0, 8'd7},  // R7 ternary alias
    '{1'b0, 3'd1, 3'd2, 3'd3, 4'h0, 8'hFF, 32'h12345678, 32'h12345678, 1'b1, 8'd5},  // R5 zero mask
    '{1'b1, 3'd6, 3'd7, 3'd0, 4'h6, 8'h00, 32'hF0000000, 32'hF0000060, 1'b0, 8'd4},  // R4 lanes 1,2, R6
    '{1'b1, 3'd3, 3'd4, 3'd5, 4'hF, 8'hFF, 32'h000CA600, 32'h0006A600, 1'b0, 8'd8},  // R8 reserved bits set
    '{1'b1, 3'd4, 3'd0, 3'd1, 4'h0, 8'h00, 32'hA5A5A5A5, 32'hA5A5A5A5, 1'b1, 8'd5}   // R5 zero mask binary
  };

  function automatic logic [31:0] mkInstr(input logic [5:0] po, input logic [4:0] xo,
      input logic [2:0] d, input logic [2:0] a, input logic [2:0] b,
      input logic [3:0] m, input logic [7:0] t);
    logic [31:0] w;
    w = '0;
    w[31:26] = po;
    w[25:23] = d;
    w[22] = m[0];
    w[21] = m[1];
    w[20:18] = a;
    w[17] = m[2];
    w[16] = m[3];
    w[15:13] = b;
    for (int k = 0; k < 7; k++) w[12-k] = t[k];
    w[5:1] = xo;
    w[0] = t[7];
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] expCr, input logic expIll);
    checks++;
    if (crOut !== expCr || illegalOut !== expIll) begin
      errors++;
      $display("FAIL %s: crOut=%h illegal=%b expected crOut=%h illegal=%b",
               tag, crOut, illegalOut, expCr, expIll);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] c);
    @(negedge clk);
    instrIn = w;
    crIn = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expired expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset holds outputs at zero despite live inputs
    instrIn = mkInstr(MAJ, XO_T, 3'd0, 3'd1, 3'd2, 4'hF, 8'hFF);
    crIn = 32'hDEADBEEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset", 32'h0, 1'b0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      string tag;
      apply(mkInstr(MAJ, VECS[v].isBin ? XO_B : XO_T, VECS[v].dst, VECS[v].srcA,
                    VECS[v].srcB, VECS[v].mask, VECS[v].tbl), VECS[v].cr);
      tag = $sformatf("R%0d vector %0d", VECS[v].req, v);
      check(tag, VECS[v].exp, VECS[v].ill);
    end

    // R9: wrong major opcode traps, register unchanged
    apply(mkInstr(6'd23, XO_T, 3'd0, 3'd1, 3'd2, 4'hF, 8'hFF), 32'h01234567);
    check("R9 major opcode", 32'h01234567, 1'b0 | 1'b1);

    // R9: unknown extended opcode traps
    apply(mkInstr(MAJ, 5'd12, 3'd0, 3'd1, 3'd2, 4'hF, 8'hFF), 32'h89ABCDEF);
    check("R9 extended opcode", 32'h89ABCDEF, 1'b1);

    // R10: one-cycle latency; output still holds the previous result before the edge
    @(negedge clk);
    instrIn = mkInstr(MAJ, XO_T, 3'd7, 3'd0, 3'd0, 4'hF, 8'hFF);
    crIn = 32'h00000000;
    #1;
    check("R10 latency before edge", 32'h89ABCDEF, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R10 latency after edge", 32'h0000000F, 1'b0);

    // R1 R6: last field written with all-ones table, other fields untouched
    apply(mkInstr(MAJ, XO_T, 3'd7, 3'd3, 3'd5, 4'hF, 8'hFF), 32'h76543210);
    check("R1 R6 last field", 32'h7654321F, 1'b0);

    // R4: single lane 2 written to 1 in field 0
    apply(mkInstr(MAJ, XO_T, 3'd0, 3'd1, 3'd2, 4'h4, 8'hFF), 32'h00000000);
    check("R4 single lane", 32'h20000000, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule